// File: doc/BRIEF.md
# PHY Management Transaction Controller

This block gives a host a two-register window onto the management registers of up to 32 PHY devices. The host first places a 16-bit value in the data register (for writes), then writes the command register with a PHY address, a PHY register address and a direction bit. That single write launches a transaction and raises a busy flag. The flag drops on its own when the transaction ends. A read transaction leaves the PHY's answer in the data register. A write transaction sends the data register to the PHY and leaves it unchanged.

The bit-serial management line is not modelled. The PHY side uses a parallel request channel with valid/ready, followed by a response strobe. The request (`req_valid` with PHY address, register, direction and write data) is held steady until the PHY raises `req_ready`. The PHY may apply back-pressure for any number of cycles. The response channel has no ready: the controller always takes `rsp_valid` once the request has been accepted, and ignores it before that. A response with `rsp_present` low means no PHY answered. The controller also has a timeout. If a transaction does not finish within `TIMEOUT` cycles it is abandoned, `req_valid` is withdrawn, and the transaction is treated as an absent PHY.

Top module: `mii_sta_ctrl`

## Requirements
- R1: After reset both registers read as zero, `busy` is low and `req_valid` is low.
- R2: A host write to the command register (`host_sel`=0) while idle sets `busy` and raises `req_valid` from the next cycle. The command register layout is: bit 0 busy (read-only, write ignored), bit 1 direction (1 = write to PHY, 0 = read from PHY), bits 6:2 PHY register address, bits 11:7 PHY address. Bits 15:12 read as zero. The request ports carry the written fields.
- R3: `req_valid` stays high, with all request fields stable, until `req_ready` is seen. It is low from the cycle after acceptance.
- R4: A write transaction presents the data register on `req_wdata` with `req_write`=1. The data register is unchanged after completion, whatever the response carries.
- R5: On the clock edge where `rsp_valid` is sampled after acceptance, `busy` clears. For a read with `rsp_present`=1, the data register takes `rsp_data`.
- R6: A read whose response has `rsp_present`=0 loads 0xFFFF into the data register.
- R7: A transaction that has not completed after `TIMEOUT` clock edges from the launching write ends on that edge. `busy` is high for exactly `TIMEOUT` cycles, `req_valid` drops, and a read loads 0xFFFF.
- R8: Host writes to either register while `busy` is high have no effect on the registers or on the request in flight.
- R9: While idle, a host write to the data register (`host_sel`=1) stores all 16 bits, which then read back on `host_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | Register select: 0 command, 1 data |
| host_wdata | input | 16 | Host write value |
| host_rdata | output | 16 | Selected register contents (combinational) |
| busy | output | 1 | Transaction in progress |
| req_valid | output | 1 | Request to PHY valid |
| req_ready | input | 1 | PHY accepts request |
| req_phy | output | 5 | Target PHY address |
| req_reg | output | 5 | Target PHY register |
| req_write | output | 1 | 1 write, 0 read |
| req_wdata | output | 16 | Data for a write |
| rsp_valid | input | 1 | PHY response strobe |
| rsp_present | input | 1 | PHY answered |
| rsp_data | input | 16 | Read data from PHY |

## Verification
The launching write is registered, so `busy` and `req_valid` are due one edge after the write strobe. Acceptance by `req_ready` drops `req_valid` one edge later. The response strobe clears `busy` and updates the data register on the same edge that samples it. The timeout ends a transaction exactly `TIMEOUT` edges after launch. The bench drives and samples only at falling edges and checks each result at the first falling edge after the edge that produces it. For the timeout it counts the falling edges with `busy` high. The sweep covers every PHY address, a spread of register addresses, both directions, present and absent PHYs, and varying acceptance and response delays.

// File: rtl/mii_sta_pkg.sv
package mii_sta_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_AWAIT = 2'd2
  } seq_state_t;

  localparam logic SEL_CMD  = 1'b0;
  localparam logic SEL_DATA = 1'b1;

  localparam int BUSY_BIT = 0;
  localparam int DIR_BIT  = 1;
  localparam int REG_LSB  = 2;
endpackage

// File: rtl/mii_sta_timer.sv
module mii_sta_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == LAST);

  // R7: the counter never passes the abandon point while a transaction runs
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= LAST));
endmodule

// File: rtl/mii_sta_seq.sv
module mii_sta_seq
  import mii_sta_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_write,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_present,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              expired,
  output logic              req_valid,
  output logic              run,
  output logic              done,
  output logic              done_load,
  output logic [DATA_W-1:0] done_value
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d    = state_q;
    done       = 1'b0;
    done_load  = 1'b0;
    done_value = '1;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_ISSUE;
      ST_ISSUE: begin
        if (expired) begin
          done      = 1'b1;
          done_load = !dir_write;
          state_d   = ST_IDLE;
        end else if (req_ready) begin
          state_d = ST_AWAIT;
        end
      end
      ST_AWAIT: begin
        if (rsp_valid) begin
          done       = 1'b1;
          done_load  = !dir_write;
          done_value = rsp_present ? rsp_data : '1;
          state_d    = ST_IDLE;
        end else if (expired) begin
          done      = 1'b1;
          done_load = !dir_write;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign run       = (state_q != ST_IDLE);
  assign req_valid = (state_q == ST_ISSUE) && !expired;

  // R2: a launch always produces a request in the following cycle
  a_r2_start_issues: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> req_valid);
  // R3: an accepted request is not offered again
  a_r3_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);
endmodule

// File: rtl/mii_sta_regs.sv
module mii_sta_regs
  import mii_sta_pkg::*;
#(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              done,
  input  logic              done_load,
  input  logic [DATA_W-1:0] done_value,
  output logic              start,
  output logic              busy,
  output logic              dir_write,
  output logic [PHY_AW-1:0] phy_addr,
  output logic [REG_AW-1:0] reg_addr,
  output logic [DATA_W-1:0] data
);
  localparam int PHY_LSB = REG_LSB + REG_AW;

  logic              busy_q, dir_q;
  logic [PHY_AW-1:0] phy_q;
  logic [REG_AW-1:0] reg_q;
  logic [DATA_W-1:0] data_q;
  logic              data_wr;

  assign start   = host_we && (host_sel == SEL_CMD) && !busy_q;
  assign data_wr = host_we && (host_sel == SEL_DATA) && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      phy_q  <= '0;
      reg_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      dir_q  <= host_wdata[DIR_BIT];
      reg_q  <= host_wdata[REG_LSB +: REG_AW];
      phy_q  <= host_wdata[PHY_LSB +: PHY_AW];
    end else if (done) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                data_q <= '0;
    else if (data_wr)          data_q <= host_wdata;
    else if (done && done_load) data_q <= done_value;
  end

  always_comb begin
    host_rdata = '0;
    if (host_sel == SEL_CMD) begin
      host_rdata[BUSY_BIT]               = busy_q;
      host_rdata[DIR_BIT]                = dir_q;
      host_rdata[REG_LSB +: REG_AW]      = reg_q;
      host_rdata[PHY_LSB +: PHY_AW]      = phy_q;
    end else begin
      host_rdata = data_q;
    end
  end

  assign busy      = busy_q;
  assign dir_write = dir_q;
  assign phy_addr  = phy_q;
  assign reg_addr  = reg_q;
  assign data      = data_q;

  // R8: while a transaction is in flight the command fields do not move
  a_r8_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(phy_q) && $stable(reg_q) && $stable(dir_q)));
  // R8: data only changes when the transaction ends
  a_r8_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(data_q));
  // R5: completion from the sequencer always releases busy
  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
endmodule

// File: rtl/mii_sta_ctrl.sv
module mii_sta_ctrl #(
  parameter int PHY_AW  = 5,
  parameter int REG_AW  = 5,
  parameter int DATA_W  = 16,
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [PHY_AW-1:0] req_phy,
  output logic [REG_AW-1:0] req_reg,
  output logic              req_write,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_present,
  input  logic [DATA_W-1:0] rsp_data
);
  logic              start, run, expired;
  logic              done, done_load;
  logic [DATA_W-1:0] done_value;

  mii_sta_regs #(
    .PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .done(done), .done_load(done_load), .done_value(done_value),
    .start(start), .busy(busy), .dir_write(req_write),
    .phy_addr(req_phy), .reg_addr(req_reg), .data(req_wdata)
  );

  mii_sta_seq #(.DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .start(start), .dir_write(req_write),
    .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_present(rsp_present), .rsp_data(rsp_data),
    .expired(expired), .req_valid(req_valid), .run(run),
    .done(done), .done_load(done_load), .done_value(done_value)
  );

  mii_sta_timer #(.LIMIT(TIMEOUT)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(run), .expired(expired)
  );

  // R7: no request is offered outside a transaction
  a_r7_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);
  // R3: a stalled request keeps its fields
  a_r3_req_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> ($stable(req_phy) && $stable(req_reg) &&
                                   $stable(req_write) && $stable(req_wdata)));
endmodule

// File: tb/mii_sta_ctrl_tb.sv
`timescale 1ns/1ps
module mii_sta_ctrl_tb_top;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0, host_sel = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        busy, req_valid, req_write;
  logic        req_ready = 1'b0;
  logic [4:0]  req_phy, req_reg;
  logic [15:0] req_wdata;
  logic        rsp_valid = 1'b0, rsp_present = 1'b0;
  logic [15:0] rsp_data = '0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  mii_sta_ctrl #(.TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_phy(req_phy),
    .req_reg(req_reg), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_present(rsp_present), .rsp_data(rsp_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] phy_val(int p, int r);
    return 16'hA5C3 ^ {5'(p), 5'(r), 6'(p + r)};
  endfunction

  function automatic bit phy_here(int p);
    return (p % 3) != 2;
  endfunction

  function automatic logic [15:0] cmd_word(int p, int r, bit wr);
    return {4'b0, 5'(p), 5'(r), wr, 1'b1};
  endfunction

  task automatic read_reg(logic sel, output logic [15:0] v);
    host_sel = sel;
    #0.5;
    v = host_rdata;
  endtask

  task automatic host_write(logic sel, logic [15:0] v);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic run_txn(int p, int r, bit wr, logic [15:0] dval, int acc, int rsp);
    logic [15:0] v;
    logic [15:0] exp_data;
    if (wr) begin
      host_write(1'b1, dval);
      read_reg(1'b1, v);
      check("R9 data readback", v, dval);
    end else begin
      read_reg(1'b1, v);
      dval = v;
    end
    host_write(1'b0, cmd_word(p, r, wr));
    check("R2 busy set", busy, 1);
    read_reg(1'b0, v);
    check("R2 cmd readback", v, {4'b0, 5'(p), 5'(r), wr, 1'b1});
    check("R2 req fields", {req_valid, req_phy, req_reg, req_write},
          {1'b1, 5'(p), 5'(r), wr});
    if (wr) check("R4 req wdata", req_wdata, dval);
    for (int i = 0; i < acc; i++) begin
      @(negedge clk);
      check("R3 held under back-pressure", {req_valid, req_phy, req_reg}, {1'b1, 5'(p), 5'(r)});
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    check("R3 drop after accept", {req_valid, busy}, 2'b01);
    for (int i = 0; i < rsp; i++) @(negedge clk);
    rsp_valid = 1'b1; rsp_present = phy_here(p);
    rsp_data = phy_here(p) ? phy_val(p, r) : 16'h1357;
    if (wr) rsp_data = 16'hDEAD;
    @(negedge clk);
    rsp_valid = 1'b0;
    check("R5 busy clears on response", busy, 0);
    exp_data = wr ? dval : (phy_here(p) ? phy_val(p, r) : 16'hFFFF);
    read_reg(1'b1, v);
    if (wr) check("R4 data unchanged after write", v, exp_data);
    else if (phy_here(p)) check("R5 read data", v, exp_data);
    else check("R6 absent reads ones", v, exp_data);
  endtask

  task automatic run_timeout(bit accept, bit wr);
    int n = 0;
    logic [15:0] v;
    host_write(1'b1, 16'h0F0F);
    host_write(1'b0, cmd_word(9, 4, wr));
    if (accept) begin
      req_ready = 1'b1; n++;
      @(negedge clk);
      req_ready = 1'b0;
    end
    while (busy && n < 4 * TMO) begin
      n++;
      @(negedge clk);
    end
    check("R7 busy length", n, TMO);
    check("R7 request withdrawn", req_valid, 0);
    read_reg(1'b1, v);
    check("R7 data after timeout", v, wr ? 16'h0F0F : 16'hFFFF);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_reg(1'b0, v); check("R1 cmd reset", v, 0);
    read_reg(1'b1, v); check("R1 data reset", v, 0);
    check("R1 outputs idle", {busy, req_valid}, 0);

    for (int p = 0; p < 32; p++) begin
      for (int k = 0; k < 4; k++) begin
        int r = (k * 11 + p) % 32;
        run_txn(p, r, 1'b0, 16'h0, (p + r) % 4, (3 * p + r) % 4);
        run_txn(p, r, 1'b1, 16'(p * 977 + r * 31), (p + k) % 4, (p + 2 * k) % 4);
      end
    end

    // R8: writes while busy are ignored
    host_write(1'b1, 16'h2468);
    host_write(1'b0, cmd_word(4, 17, 1'b0));
    host_write(1'b0, cmd_word(30, 3, 1'b1));
    host_write(1'b1, 16'hBEEF);
    read_reg(1'b0, v);
    check("R8 cmd unchanged", v, {4'b0, 5'd4, 5'd17, 1'b0, 1'b1});
    check("R8 request unchanged", {req_valid, req_phy, req_reg, req_write},
          {1'b1, 5'd4, 5'd17, 1'b0});
    read_reg(1'b1, v);
    check("R8 data unchanged", v, 16'h2468);
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    rsp_valid = 1'b1; rsp_present = 1'b1; rsp_data = 16'h7711;
    @(negedge clk); rsp_valid = 1'b0;
    read_reg(1'b1, v);
    check("R8 read completes with phy data", v, 16'h7711);

    // response before acceptance is ignored (R5 timing)
    host_write(1'b0, cmd_word(2, 2, 1'b0));
    rsp_valid = 1'b1; rsp_present = 1'b1; rsp_data = 16'h0001;
    @(negedge clk); rsp_valid = 1'b0;
    check("R5 early response ignored", {busy, req_valid}, 2'b11);
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    rsp_valid = 1'b1; rsp_data = 16'h0002;
    @(negedge clk); rsp_valid = 1'b0;
    read_reg(1'b1, v);
    check("R5 only accepted response loads", v, 16'h0002);

    run_timeout(1'b0, 1'b0);
    run_timeout(1'b1, 1'b0);
    run_timeout(1'b0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule